// File: doc/BRIEF.md
# Interrupt Source Aggregator with Bus Register Access

This block gathers a configurable number (2 to 64) of level-sensitive interrupt lines, all synchronous to the bus clock. It combines them into one request line for a parent interrupt controller. Each line passes through two per-source gates before it reaches the request line: an enable bit, where 1 admits the source, and a mask bit, where 1 blocks it. Software reads a pair of 32-bit pending words to learn which sources are active and admitted. It then services them by scanning those words.

Each control word is split into a lower half for sources 0 to 31 and an upper half for sources 32 to 63. Storage exists only for configured sources. A bit beyond the configured count ignores writes and reads back as zero, so software can find the source count by writing all ones to the enable words and reading them back. Register access uses an APB slave port with no wait states. The ungated source levels can also be read, for debug.

Top module: `intagg_top`

## Requirements
- R1: After a synchronous reset, every enable bit and every mask bit is 0, `irq_o` is 0 and both pending words read 0.
- R2: The enable words sit at offset 0x00 (sources 0 to 31) and offset 0x04 (sources 32 to 63). Bit b of the word at 0x04 controls source 32+b. A written value reads back for configured sources only; with 40 sources, writing all ones reads back 0xFFFFFFFF at 0x00 and 0x000000FF at 0x04.
- R3: The mask words sit at offset 0x08 (sources 0 to 31) and offset 0x0C (sources 32 to 63). They use the same bit mapping and the same zero read-back for unconfigured bits as the enable words.
- R4: The pending words sit at offset 0x30 (low) and offset 0x34 (high). Bit b of the low word is source b, and bit b of the high word is source 32+b. Each bit equals input AND enable AND NOT mask.
- R5: The raw words at offset 0x18 (low) and offset 0x1C (high) report the ungated input levels with the same bit mapping. Enable and mask have no effect on them.
- R6: The raw and pending words are read-only. A write to 0x18, 0x1C, 0x30 or 0x34 changes no enable or mask bit.
- R7: `irq_o` is the OR of all pending bits, registered once. It changes on the first rising clock edge after the pending set changes, and it is 0 when no bit is pending.
- R8: Any offset other than the eight listed reads as zero, and a write to it changes nothing. `pready` is always 1 and `pslverr` is always 0.
- R9: A pending bit stays set for as long as its input is high and the source is admitted. Reading the pending words does not clear it, and it drops when the input falls.
- R10: When 32 or fewer sources are configured (for example 20), the enable word at 0x04 reads zero after an all-ones write, and the word at 0x00 reads back only the configured bits (0x000FFFFF for 20 sources).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during a read |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 |
| src_i | input | NUM_SRC | Level-sensitive interrupt inputs |
| irq_o | output | 1 | Combined request to the parent controller |

## Verification
The hardest case to reach is a source in the upper word when only part of that word is configured. Its enable, mask and pending bits must follow the source index, and its neighbours just above the configured count must stay zero. The stimulus writes all ones over the upper words and drives inputs across the 39/40 boundary, then reads back every word. A second instance configured with 20 sources covers the empty upper word. Level persistence is shown by reading the pending words repeatedly while an input is held high, then letting the input fall and confirming that the pending bit and `irq_o` both drop.

// File: rtl/intagg_pkg.sv
package intagg_pkg;

    localparam int WORD_W  = 32;
    localparam int MAX_SRC = 64;
    localparam int OFF_W   = 8;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_MSK_LO,
        SEL_MSK_HI,
        SEL_RAW_LO,
        SEL_RAW_HI,
        SEL_PND_LO,
        SEL_PND_HI
    } sel_e;

    typedef struct packed {
        logic              wr_stb;
        logic              rd_act;
        sel_e              sel;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    function automatic sel_e decode_off(input logic [OFF_W-1:0] a);
        sel_e s;
        case (a)
            8'h00:   s = SEL_EN_LO;
            8'h04:   s = SEL_EN_HI;
            8'h08:   s = SEL_MSK_LO;
            8'h0C:   s = SEL_MSK_HI;
            8'h18:   s = SEL_RAW_LO;
            8'h1C:   s = SEL_RAW_HI;
            8'h30:   s = SEL_PND_LO;
            8'h34:   s = SEL_PND_HI;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input logic [MAX_SRC-1:0] v,
                                                    input logic hi);
        return hi ? v[MAX_SRC-1:WORD_W] : v[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
    import intagg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [WORD_W-1:0]   pwdata,
    output bus_req_t            req
);
    logic              upper_hit;
    logic [OFF_W-1:0]  low_off;

    generate
        if (ADDR_W > OFF_W) begin : g_wide
            assign upper_hit = |paddr[ADDR_W-1:OFF_W];
            assign low_off   = paddr[OFF_W-1:0];
        end else begin : g_narrow
            assign upper_hit = 1'b0;
            assign low_off   = OFF_W'(paddr);
        end
    endgenerate

    always_comb begin
        req.wr_stb = psel && penable && pwrite;
        req.rd_act = psel && !pwrite;
        req.sel    = upper_hit ? SEL_NONE : decode_off(low_off);
        req.wdata  = pwdata;
    end
endmodule

// File: rtl/intagg_regs.sv
module intagg_regs
    import intagg_pkg::*;
#(
    parameter int N = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_req_t      req,
    output logic [N-1:0]  en_q,
    output logic [N-1:0]  msk_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int   WI     = i / WORD_W;
        localparam int   BI     = i % WORD_W;
        localparam sel_e EN_SEL = (WI == 0) ? SEL_EN_LO  : SEL_EN_HI;
        localparam sel_e MK_SEL = (WI == 0) ? SEL_MSK_LO : SEL_MSK_HI;

        logic en_b;
        logic mk_b;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_b <= 1'b0;
                mk_b <= 1'b0;
            end else if (req.wr_stb) begin
                if (req.sel == EN_SEL) en_b <= req.wdata[BI];
                if (req.sel == MK_SEL) mk_b <= req.wdata[BI];
            end
        end

        assign en_q[i]  = en_b;
        assign msk_q[i] = mk_b;
    end
endmodule

// File: rtl/intagg_gate.sv
module intagg_gate #(
    parameter int N = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src,
    input  logic [N-1:0]  en,
    input  logic [N-1:0]  msk,
    output logic [N-1:0]  pend,
    output logic          irq_q
);
    assign pend = src & en & ~msk;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend;
    end
endmodule

// File: rtl/intagg_rdmux.sv
module intagg_rdmux
    import intagg_pkg::*;
(
    input  bus_req_t             req,
    input  logic [MAX_SRC-1:0]   en64,
    input  logic [MAX_SRC-1:0]   msk64,
    input  logic [MAX_SRC-1:0]   raw64,
    input  logic [MAX_SRC-1:0]   pnd64,
    output logic [WORD_W-1:0]    rdata
);
    logic [WORD_W-1:0] word;

    always_comb begin
        case (req.sel)
            SEL_EN_LO:  word = pick_word(en64,  1'b0);
            SEL_EN_HI:  word = pick_word(en64,  1'b1);
            SEL_MSK_LO: word = pick_word(msk64, 1'b0);
            SEL_MSK_HI: word = pick_word(msk64, 1'b1);
            SEL_RAW_LO: word = pick_word(raw64, 1'b0);
            SEL_RAW_HI: word = pick_word(raw64, 1'b1);
            SEL_PND_LO: word = pick_word(pnd64, 1'b0);
            SEL_PND_HI: word = pick_word(pnd64, 1'b1);
            default:    word = '0;
        endcase
        rdata = req.rd_act ? word : '0;
    end
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int ADDR_W  = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    output logic                pslverr,
    input  logic [NUM_SRC-1:0]  src_i,
    output logic                irq_o
);
    bus_req_t            req;
    logic [NUM_SRC-1:0]  en_q;
    logic [NUM_SRC-1:0]  msk_q;
    logic [NUM_SRC-1:0]  pend;
    logic [MAX_SRC-1:0]  en64, msk64, raw64, pnd64;

    intagg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .req     (req)
    );

    intagg_regs #(.N(NUM_SRC)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .en_q  (en_q),
        .msk_q (msk_q)
    );

    intagg_gate #(.N(NUM_SRC)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .src   (src_i),
        .en    (en_q),
        .msk   (msk_q),
        .pend  (pend),
        .irq_q (irq_o)
    );

    assign en64  = MAX_SRC'(en_q);
    assign msk64 = MAX_SRC'(msk_q);
    assign raw64 = MAX_SRC'(src_i);
    assign pnd64 = MAX_SRC'(pend);

    intagg_rdmux u_rd (
        .req   (req),
        .en64  (en64),
        .msk64 (msk64),
        .raw64 (raw64),
        .pnd64 (pnd64),
        .rdata (prdata)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;
endmodule

// File: rtl/intagg_chk.sv
module intagg_chk #(
    parameter int N      = 40,
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               psel,
    input logic               penable,
    input logic               pwrite,
    input logic [ADDR_W-1:0]  paddr,
    input logic [31:0]        prdata,
    input logic               pready,
    input logic               pslverr,
    input logic [N-1:0]       src_i,
    input logic               irq_o,
    input logic [N-1:0]       en_q,
    input logic [N-1:0]       msk_q
);
    logic [63:0] exp_pnd;
    logic        st_wr;
    logic        unmapped;

    assign exp_pnd = 64'(src_i & en_q & ~msk_q);
    assign st_wr   = psel && penable && pwrite &&
                     (paddr == ADDR_W'(8'h30) || paddr == ADDR_W'(8'h34) ||
                      paddr == ADDR_W'(8'h18) || paddr == ADDR_W'(8'h1C));
    assign unmapped = !(paddr == ADDR_W'(8'h00) || paddr == ADDR_W'(8'h04) ||
                        paddr == ADDR_W'(8'h08) || paddr == ADDR_W'(8'h0C) ||
                        paddr == ADDR_W'(8'h18) || paddr == ADDR_W'(8'h1C) ||
                        paddr == ADDR_W'(8'h30) || paddr == ADDR_W'(8'h34));

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (en_q == '0 && msk_q == '0 && !irq_o));                              // R1

    AST_PND_LO_READ: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && paddr == ADDR_W'(8'h30)) |-> prdata == exp_pnd[31:0]);  // R4

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> ($stable(en_q) && $stable(msk_q)));                               // R6

    AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|exp_pnd));                                                  // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && unmapped) |-> prdata == 32'h0);                         // R8

    AST_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        pready && !pslverr);                                                        // R8
endmodule

bind intagg_top intagg_chk #(.N(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .prdata  (prdata),
    .pready  (pready),
    .pslverr (pslverr),
    .src_i   (src_i),
    .irq_o   (irq_o),
    .en_q    (en_q),
    .msk_q   (msk_q)
);

// File: tb/sim_intagg_top.sv
module sim_intagg_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC0 = 40;
    localparam int NSRC1 = 20;
    localparam logic [63:0] IMPL0 = (64'h1 << NSRC0) - 64'h1;

    // each entry: {src, enable, mask}
    localparam logic [191:0] VEC [6] = '{
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000},
        {64'h0000_00F0_0000_00F0, 64'h0000_00FF_0000_00FF, 64'h0000_0010_0000_0010},
        {64'h0000_0080_8000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
        {64'h0000_00AA_5555_AAAA, 64'h0000_00FF_FFFF_0000, 64'h0000_000F_0F0F_0000},
        {64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000, 64'h0000_0001_0000_0000},
        {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000}
    };

    logic              clk = 0;
    logic              rst = 1;
    logic              psel = 0, penable = 0, pwrite = 0;
    logic [7:0]        paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata, prdata1;
    logic              pready, pslverr, pready1, pslverr1;
    logic [NSRC0-1:0]  src = '0;
    logic              irq, irq1;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    intagg_top #(.NUM_SRC(NSRC0), .ADDR_W(8)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .src_i(src), .irq_o(irq)
    );

    intagg_top #(.NUM_SRC(NSRC1), .ADDR_W(8)) u1 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata1), .pready(pready1),
        .pslverr(pslverr1), .src_i(src[NSRC1-1:0]), .irq_o(irq1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
        @(negedge clk);
        penable = 1;
        @(posedge clk);
        #1;
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d0, output logic [31:0] d1);
        @(negedge clk);
        psel = 1; pwrite = 0; paddr = a; penable = 0;
        @(negedge clk);
        penable = 1;
        #1;
        d0 = prdata; d1 = prdata1;
        @(posedge clk);
        #1;
        psel = 0; penable = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r0, r1;
        logic [63:0] v_src, v_en, v_msk, exp_p;

        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        bus_rd(8'h00, r0, r1); chk("R1 enable lo", r0, 32'h0);
        bus_rd(8'h0C, r0, r1); chk("R1 mask hi", r0, 32'h0);
        bus_rd(8'h30, r0, r1); chk("R1 pending lo", r0, 32'h0);
        bus_rd(8'h34, r0, r1); chk("R1 pending hi", r0, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 / R10: implemented enable bits only
        bus_wr(8'h00, 32'hFFFF_FFFF);
        bus_wr(8'h04, 32'hFFFF_FFFF);
        bus_rd(8'h00, r0, r1);
        chk("R2 enable lo", r0, 32'hFFFF_FFFF);
        chk("R10 enable lo 20 src", r1, 32'h000F_FFFF);
        bus_rd(8'h04, r0, r1);
        chk("R2 enable hi", r0, 32'h0000_00FF);
        chk("R10 enable hi 20 src", r1, 32'h0);

        // R3: mask read-back
        bus_wr(8'h0C, 32'hFFFF_FFFF);
        bus_wr(8'h08, 32'h1234_5678);
        bus_rd(8'h0C, r0, r1); chk("R3 mask hi", r0, 32'h0000_00FF);
        bus_rd(8'h08, r0, r1); chk("R3 mask lo", r0, 32'h1234_5678);

        // table-driven: R4 pending, R5 raw, R7 irq
        for (int i = 0; i < 6; i++) begin
            {v_src, v_en, v_msk} = VEC[i];
            bus_wr(8'h00, v_en[31:0]);
            bus_wr(8'h04, v_en[63:32]);
            bus_wr(8'h08, v_msk[31:0]);
            bus_wr(8'h0C, v_msk[63:32]);
            @(negedge clk);
            src = v_src[NSRC0-1:0];
            exp_p = v_src & v_en & ~v_msk & IMPL0;
            bus_rd(8'h30, r0, r1); chk($sformatf("R4 vec%0d pending lo", i), r0, exp_p[31:0]);
            bus_rd(8'h34, r0, r1); chk($sformatf("R4 vec%0d pending hi", i), r0, exp_p[63:32]);
            bus_rd(8'h18, r0, r1); chk($sformatf("R5 vec%0d raw lo", i), r0, v_src[31:0]);
            bus_rd(8'h1C, r0, r1); chk($sformatf("R5 vec%0d raw hi", i), r0, v_src[63:32] & IMPL0[63:32]);
            @(negedge clk);
            chk($sformatf("R7 vec%0d irq", i), {31'h0, irq}, {31'h0, |exp_p});
        end

        // R7: one-cycle latency from input to irq
        bus_wr(8'h00, 32'h0000_0001);
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h0C, 32'h0);
        @(negedge clk);
        src = '0;
        @(negedge clk);
        chk("R7 irq idle", {31'h0, irq}, 32'h0);
        src[0] = 1'b1;
        #1;
        chk("R7 irq before edge", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 irq after edge", {31'h0, irq}, 32'h1);
        src[0] = 1'b0;
        @(negedge clk);
        chk("R7 irq falls", {31'h0, irq}, 32'h0);

        // R6: writes to status words ignored
        bus_wr(8'h30, 32'hFFFF_FFFF);
        bus_wr(8'h34, 32'hFFFF_FFFF);
        bus_wr(8'h18, 32'hFFFF_FFFF);
        bus_wr(8'h1C, 32'hFFFF_FFFF);
        bus_rd(8'h00, r0, r1); chk("R6 enable lo kept", r0, 32'h0000_0001);
        bus_rd(8'h08, r0, r1); chk("R6 mask lo kept", r0, 32'h0);
        bus_rd(8'h30, r0, r1); chk("R6 pending lo kept", r0, 32'h0);

        // R8: unmapped offsets, write to unmapped has no effect
        bus_wr(8'h10, 32'hFFFF_FFFF);
        bus_wr(8'h44, 32'hFFFF_FFFF);
        bus_rd(8'h10, r0, r1); chk("R8 unmapped 0x10", r0, 32'h0);
        bus_rd(8'h44, r0, r1); chk("R8 unmapped 0x44", r0, 32'h0);
        bus_rd(8'h32, r0, r1); chk("R8 unaligned 0x32", r0, 32'h0);
        bus_rd(8'h04, r0, r1); chk("R8 enable hi untouched", r0, 32'h0);
        chk("R8 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);

        // R9: level persistence on source 39 (high word bit 7)
        bus_wr(8'h04, 32'h0000_0080);
        @(negedge clk);
        src[39] = 1'b1;
        bus_rd(8'h34, r0, r1); chk("R9 pending hi first", r0, 32'h0000_0080);
        bus_rd(8'h34, r0, r1); chk("R9 pending hi after read", r0, 32'h0000_0080);
        chk("R9 irq held", {31'h0, irq}, 32'h1);
        @(negedge clk);
        src[39] = 1'b0;
        bus_rd(8'h34, r0, r1); chk("R9 pending hi cleared", r0, 32'h0);
        chk("R9 irq dropped", {31'h0, irq}, 32'h0);

        // R1: reset clears programmed state
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        bus_rd(8'h04, r0, r1); chk("R1 enable hi after reset", r0, 32'h0);
        bus_rd(8'h00, r0, r1); chk("R1 enable lo after reset", r0, 32'h0);

        finish_run();
    end
endmodule